// File: doc/BRIEF.md
# Scaled 64-Bit System Counter

This block keeps a 64-bit system time value that advances on each input clock while enabled. Software reaches it through two 4 KB register frames on a 32-bit memory-mapped bus, chosen by a frame-select input. The control frame holds the enable and scale-enable bits, an 8.24 fixed-point step register, the counter value as two writable 32-bit halves, and fixed identification words. The status frame is a read-only view of the same live counter with its own identification bytes.

When the scale-enable bit is clear, the counter gains exactly one per clock. When it is set, every clock adds the step register divided by 2^24. A 24-bit fractional accumulator holds the remainder, so a step that is not a whole number never drifts. Bus reads are combinational from the current state. Writes take effect on the rising clock edge at which `bus_valid` and `bus_write` are both high. Only full 32-bit accesses are supported, so address bits 1:0 are ignored.

Top module: `syscnt_top`

## Requirements
- R1: The control word at offset 0x000 of the control frame stores bits 4:0 of a write and reads them back zero-extended. Bit 5 and every higher bit are dropped. Bit 0 is enable and bit 2 is scale enable.
- R2: While enable is 0 and no counter half is written, the counter value does not change.
- R3: While enable is 1 and scale enable is 0, the counter gains exactly 1 per clock, with carry from the low half into the high half.
- R4: The step register resets to 0x01000000 and can be read and written at control offsets 0x010 and 0x0D0. Offset 0x0D4 always reads 0, and writes to it change nothing.
- R5: While enable and scale enable are both 1, each clock adds step/2^24 to the counter. The remainder is kept in a 24-bit fraction, so five steps of 1.5 add exactly 7.
- R6: The counter low half sits at control offset 0x008 and the high half at 0x00C. Writing one half replaces only those 32 bits and keeps the other half.
- R7: Control offset 0x004 reads 0. Control offset 0x01C reads 0x00020001.
- R8: Status-frame offsets 0x000 and 0x004 read the live counter low and high halves. Every write to the status frame leaves all state unchanged.
- R9: Identification bytes occupy 0xFD0 to 0xFFC, one per 32-bit word, zero-extended. In offset order the control frame gives 04,00,00,00,BA,B0,0B,00,0D,F0,05,B1. The status frame gives the same bytes except BB in place of BA.
- R10: Reset (`rst_n` low at a clock edge) clears the control word, the counter and the fraction, and sets the step to 0x01000000.
- R11: Reads of unmapped offsets in either frame return 0. Writes to unmapped or read-only offsets change nothing.
- R12: A write to either counter half clears the fractional accumulator.
- R13: When a counter-half write and an increment fall on the same clock, the written value is stored without the increment. Counting resumes on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| frame_sel | input | 1 | 0 = control frame, 1 = status frame |
| bus_addr | input | 12 | Byte offset within the selected frame |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |

## Verification
The embedded properties check, on every cycle, these rules:
- a disabled counter holds its value;
- an unscaled counter gains exactly one;
- a half write lands unchanged and leaves the other half alone, even while counting;
- a status-frame write disturbs neither the control word nor the step;
- the step comes out of reset at 1.0.

Only the bench scenarios can show the rest:
- the fractional arithmetic over several clocks;
- the clearing of the fraction on a half write;
- the exact identification bytes;
- the masking of stored control bits;
- the zero reads of unmapped offsets.

// File: rtl/syscnt_pkg.sv
// Shared constants for the scaled system counter.
// Assumes 32-bit bus words; register offsets are word indices (byte offset >> 2).
package syscnt_pkg;
    localparam int BUS_W  = 32;
    localparam int CNT_W  = 2 * BUS_W;
    localparam int FRAC_W = 24;
    localparam int CTRL_W = 5;
    localparam int ADDR_W = 12;
    localparam int WA_W   = ADDR_W - 2;

    localparam logic [WA_W-1:0] W_CTRL  = 10'h000;
    localparam logic [WA_W-1:0] W_STAT  = 10'h001;
    localparam logic [WA_W-1:0] W_CNTLO = 10'h002;
    localparam logic [WA_W-1:0] W_CNTHI = 10'h003;
    localparam logic [WA_W-1:0] W_STEP  = 10'h004;
    localparam logic [WA_W-1:0] W_IDW   = 10'h007;
    localparam logic [WA_W-1:0] W_STEPA = 10'h034;
    localparam logic [WA_W-1:0] W_STEP1 = 10'h035;
    localparam logic [WA_W-1:0] W_IDB0  = 10'h3F4;
    localparam logic [WA_W-1:0] W_SLO   = 10'h000;
    localparam logic [WA_W-1:0] W_SHI   = 10'h001;

    localparam logic [BUS_W-1:0] STEP_ONE = 32'h0100_0000;
    localparam logic [BUS_W-1:0] ID_WORD  = 32'h0002_0001;

    // Identification byte for word index idx of the ID window.
    function automatic logic [7:0] id_byte(input logic stat, input logic [3:0] idx);
        case (idx)
            4'd0:    id_byte = 8'h04;
            4'd4:    id_byte = stat ? 8'hBB : 8'hBA;
            4'd5:    id_byte = 8'hB0;
            4'd6:    id_byte = 8'h0B;
            4'd8:    id_byte = 8'h0D;
            4'd9:    id_byte = 8'hF0;
            4'd10:   id_byte = 8'h05;
            4'd11:   id_byte = 8'hB1;
            default: id_byte = 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/syscnt_regs.sv
// Control-frame register bank: control word, step register and write strobes
// for the counter halves. Assumes full-word accesses; status-frame writes
// and writes to read-only or unmapped offsets are dropped here.
module syscnt_regs
    import syscnt_pkg::*;
#(
    parameter int DW = BUS_W,
    parameter int CW = CTRL_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_req,
    input  logic            frame_sel,
    input  logic [WA_W-1:0] wa,
    input  logic [DW-1:0]   wdata,
    output logic [CW-1:0]   ctrl_q,
    output logic [DW-1:0]   step_q,
    output logic            wr_lo,
    output logic            wr_hi
);
    logic ctl_wr;

    // Qualify writes: only the control frame accepts them.
    always_comb begin
        ctl_wr = wr_req && !frame_sel;
        wr_lo  = ctl_wr && (wa == W_CNTLO);
        wr_hi  = ctl_wr && (wa == W_CNTHI);
    end

    // Store the control bits and the step register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            step_q <= STEP_ONE;
        end else if (ctl_wr) begin
            if (wa == W_CTRL)
                ctrl_q <= wdata[CW-1:0];
            if (wa == W_STEP || wa == W_STEPA)
                step_q <= wdata;
        end
    end

    AST_STEP_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> step_q == STEP_ONE); // R4

    AST_STATUS_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && frame_sel) |=> ($stable(ctrl_q) && $stable(step_q))); // R8
endmodule

// File: rtl/syscnt_core.sv
// Counter datapath: 64-bit integer part plus a fractional accumulator.
// Assumes the step is unsigned fixed point with FW fraction bits. A half
// write wins over an increment in the same cycle and clears the fraction.
module syscnt_core
    import syscnt_pkg::*;
#(
    parameter int DW = BUS_W,
    parameter int FW = FRAC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            scale_en,
    input  logic [DW-1:0]   step,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [DW-1:0]   wdata,
    output logic [2*DW-1:0] cnt_q
);
    localparam int CW2   = 2 * DW;
    localparam int SUM_W = DW + 1;
    localparam int INC_W = SUM_W - FW;

    logic [FW-1:0]    frac_q, frac_n;
    logic [SUM_W-1:0] sum;
    logic [INC_W-1:0] inc;

    // Work out the integer increment and the next fraction.
    always_comb begin
        sum = {1'b0, step} + {{(SUM_W-FW){1'b0}}, frac_q};
        if (scale_en) begin
            inc    = sum[SUM_W-1:FW];
            frac_n = sum[FW-1:0];
        end else begin
            inc    = {{(INC_W-1){1'b0}}, 1'b1};
            frac_n = frac_q;
        end
    end

    // Update the counter: reset, then half writes, then counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            frac_q <= '0;
        end else if (wr_lo) begin
            cnt_q  <= {cnt_q[CW2-1:DW], wdata};
            frac_q <= '0;
        end else if (wr_hi) begin
            cnt_q  <= {wdata, cnt_q[DW-1:0]};
            frac_q <= '0;
        end else if (en) begin
            cnt_q  <= cnt_q + {{(CW2-INC_W){1'b0}}, inc};
            frac_q <= frac_n;
        end
    end

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_lo && !wr_hi) |=> $stable(cnt_q)); // R2

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !scale_en && !wr_lo && !wr_hi) |=> cnt_q == $past(cnt_q) + 64'd1); // R3

    AST_LO_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (cnt_q[DW-1:0] == $past(wdata)) && (cnt_q[CW2-1:DW] == $past(cnt_q[CW2-1:DW]))); // R13

    AST_HI_WRITE_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> (cnt_q[CW2-1:DW] == $past(wdata)) && (cnt_q[DW-1:0] == $past(cnt_q[DW-1:0]))); // R6
endmodule

// File: rtl/syscnt_rdmux.sv
// Read-data selection for both frames. Purely combinational.
// Assumes unmapped offsets return zero and ID bytes are zero-extended.
module syscnt_rdmux
    import syscnt_pkg::*;
#(
    parameter int DW = BUS_W,
    parameter int CW = CTRL_W
) (
    input  logic            frame_sel,
    input  logic [WA_W-1:0] wa,
    input  logic [CW-1:0]   ctrl_q,
    input  logic [DW-1:0]   step_q,
    input  logic [2*DW-1:0] cnt_q,
    output logic [DW-1:0]   rdata
);
    logic [WA_W-1:0] id_off;
    logic            in_id;

    // Pick the word for the addressed offset in the selected frame.
    always_comb begin
        id_off = wa - W_IDB0;
        in_id  = (wa >= W_IDB0);
        rdata  = '0;
        if (in_id) begin
            rdata = {{(DW-8){1'b0}}, id_byte(frame_sel, id_off[3:0])};
        end else if (frame_sel) begin
            if (wa == W_SLO)      rdata = cnt_q[DW-1:0];
            else if (wa == W_SHI) rdata = cnt_q[2*DW-1:DW];
        end else begin
            case (wa)
                W_CTRL:         rdata = {{(DW-CW){1'b0}}, ctrl_q};
                W_CNTLO:        rdata = cnt_q[DW-1:0];
                W_CNTHI:        rdata = cnt_q[2*DW-1:DW];
                W_STEP,W_STEPA: rdata = step_q;
                W_IDW:          rdata = ID_WORD;
                default:        rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/syscnt_top.sv
// Scaled 64-bit system counter with a control frame and a status frame.
// Assumes a synchronous active-low reset and full 32-bit bus accesses.
module syscnt_top
    import syscnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              frame_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata
);
    logic [WA_W-1:0]    wa;
    logic [CTRL_W-1:0]  ctrl_q;
    logic [BUS_W-1:0]   step_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               wr_lo, wr_hi, wr_req;

    // Word address and write strobe.
    always_comb begin
        wa     = bus_addr[ADDR_W-1:2];
        wr_req = bus_valid && bus_write;
    end

    syscnt_regs #(.DW(BUS_W), .CW(CTRL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .frame_sel(frame_sel),
        .wa(wa), .wdata(bus_wdata), .ctrl_q(ctrl_q), .step_q(step_q),
        .wr_lo(wr_lo), .wr_hi(wr_hi)
    );

    syscnt_core #(.DW(BUS_W), .FW(FRAC_W)) u_core (
        .clk(clk), .rst_n(rst_n), .en(ctrl_q[0]), .scale_en(ctrl_q[2]),
        .step(step_q), .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(bus_wdata),
        .cnt_q(cnt_q)
    );

    syscnt_rdmux #(.DW(BUS_W), .CW(CTRL_W)) u_rdmux (
        .frame_sel(frame_sel), .wa(wa), .ctrl_q(ctrl_q), .step_q(step_q),
        .cnt_q(cnt_q), .rdata(bus_rdata)
    );
endmodule

// File: tb/sim_syscnt_top.sv
// Bench for syscnt_top: a vector table walked by one loop, then directed
// counting, scaling, priority and reset tests. Ops start on falling edges.
module sim_syscnt_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic        frame_sel = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    syscnt_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .frame_sel(frame_sel), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    typedef struct packed {
        logic        wr;
        logic        fr;
        logic [11:0] addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b0, 12'h000, 32'h0,        32'h0,        8'd10}, // R10
        '{1'b1, 1'b0, 12'h000, 32'hFFFFFFFA, 32'h0,        8'd1},
        '{1'b0, 1'b0, 12'h000, 32'h0,        32'h1A,       8'd1},  // R1
        '{1'b1, 1'b0, 12'h000, 32'h20,       32'h0,        8'd1},
        '{1'b0, 1'b0, 12'h000, 32'h0,        32'h0,        8'd1},  // R1
        '{1'b0, 1'b0, 12'h004, 32'h0,        32'h0,        8'd7},  // R7
        '{1'b0, 1'b0, 12'h01C, 32'h0,        32'h00020001, 8'd7},  // R7
        '{1'b0, 1'b0, 12'h010, 32'h0,        32'h01000000, 8'd4},  // R4
        '{1'b0, 1'b0, 12'h0D0, 32'h0,        32'h01000000, 8'd4},  // R4
        '{1'b1, 1'b0, 12'h0D0, 32'h00123456, 32'h0,        8'd4},
        '{1'b0, 1'b0, 12'h010, 32'h0,        32'h00123456, 8'd4},  // R4
        '{1'b1, 1'b0, 12'h0D4, 32'h0000FFFF, 32'h0,        8'd4},
        '{1'b0, 1'b0, 12'h0D4, 32'h0,        32'h0,        8'd4},  // R4
        '{1'b0, 1'b0, 12'h0D0, 32'h0,        32'h00123456, 8'd4},  // R4
        '{1'b0, 1'b0, 12'hFD0, 32'h0,        32'h04,       8'd9},  // R9
        '{1'b0, 1'b0, 12'hFE0, 32'h0,        32'hBA,       8'd9},  // R9
        '{1'b0, 1'b1, 12'hFE0, 32'h0,        32'hBB,       8'd9},  // R9
        '{1'b0, 1'b1, 12'hFFC, 32'h0,        32'hB1,       8'd9},  // R9
        '{1'b0, 1'b0, 12'hFF4, 32'h0,        32'hF0,       8'd9},  // R9
        '{1'b0, 1'b1, 12'hFD4, 32'h0,        32'h00,       8'd9},  // R9
        '{1'b0, 1'b0, 12'h100, 32'h0,        32'h0,        8'd11}, // R11
        '{1'b1, 1'b0, 12'h100, 32'hFFFFFFFF, 32'h0,        8'd11},
        '{1'b0, 1'b0, 12'h000, 32'h0,        32'h0,        8'd11}, // R11
        '{1'b1, 1'b0, 12'h01C, 32'h5,        32'h0,        8'd11},
        '{1'b0, 1'b0, 12'h01C, 32'h0,        32'h00020001, 8'd11}, // R11
        '{1'b1, 1'b1, 12'h000, 32'h55,       32'h0,        8'd8},
        '{1'b0, 1'b1, 12'h000, 32'h0,        32'h0,        8'd8},  // R8
        '{1'b0, 1'b0, 12'h008, 32'h0,        32'h0,        8'd8},  // R8
        '{1'b0, 1'b1, 12'h010, 32'h0,        32'h0,        8'd11}  // R11
    };

    // Record one comparison.
    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // One-cycle write, applied at the rising edge inside the cycle.
    task automatic wr(input logic fr, input logic [11:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; frame_sel = fr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    // One-cycle read, sampled before the next rising edge.
    task automatic rd(input logic fr, input logic [11:0] a, output logic [31:0] q);
        bus_valid = 1'b1; bus_write = 1'b0; frame_sel = fr; bus_addr = a;
        #2 q = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] q;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (TBL[i].wr) wr(TBL[i].fr, TBL[i].addr, TBL[i].wd);
            else begin
                rd(TBL[i].fr, TBL[i].addr, q);
                check($sformatf("R%0d vec%0d", TBL[i].req, i), q, TBL[i].exp);
            end
        end

        // R3 / R6: unit counting with carry; 3 idle cycles + disabling edge = 4 steps
        wr(0, 12'h008, 32'hFFFFFFFE);
        wr(0, 12'h00C, 32'h0);
        wr(0, 12'h000, 32'h1);
        idle(3);
        wr(0, 12'h000, 32'h0);
        rd(0, 12'h008, q); check("R3 low after carry", q, 32'h2);
        rd(0, 12'h00C, q); check("R3 high after carry", q, 32'h1);
        rd(1, 12'h000, q); check("R8 status low mirror", q, 32'h2);
        rd(1, 12'h004, q); check("R8 status high mirror", q, 32'h1);

        // R2: disabled counter holds
        idle(5);
        rd(0, 12'h008, q); check("R2 hold while disabled", q, 32'h2);

        // R6: half writes keep the other half
        wr(0, 12'h00C, 32'h0000ABCD);
        rd(0, 12'h008, q); check("R6 low kept on high write", q, 32'h2);
        wr(0, 12'h008, 32'h7);
        rd(0, 12'h00C, q); check("R6 high kept on low write", q, 32'h0000ABCD);

        // R5: step 0.5, five steps -> +2
        wr(0, 12'h008, 32'h0);
        wr(0, 12'h00C, 32'h0);
        wr(0, 12'h010, 32'h00800000);
        wr(0, 12'h000, 32'h5);
        idle(4);
        wr(0, 12'h000, 32'h0);
        rd(0, 12'h008, q); check("R5 half step x5", q, 32'h2);

        // R12: fraction (0.5 left) must be cleared by a low write; one step -> 0
        wr(0, 12'h008, 32'h0);
        wr(0, 12'h000, 32'h5);
        wr(0, 12'h000, 32'h0);
        rd(0, 12'h008, q); check("R12 fraction cleared", q, 32'h0);

        // R5: step 1.5, five steps from 100 -> 107
        wr(0, 12'h008, 32'd100);
        wr(0, 12'h0D0, 32'h01800000);
        wr(0, 12'h000, 32'h5);
        idle(4);
        wr(0, 12'h000, 32'h0);
        rd(0, 12'h008, q); check("R5 step 1.5 x5", q, 32'd107);

        // R13: write wins over the increment in its cycle, one step follows
        wr(0, 12'h000, 32'h1);
        wr(0, 12'h008, 32'h10);
        wr(0, 12'h000, 32'h0);
        rd(0, 12'h008, q); check("R13 write priority", q, 32'h11);
        rd(0, 12'h00C, q); check("R13 high untouched", q, 32'h0);

        // R10: reset while running
        wr(0, 12'h000, 32'h1);
        idle(2);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        rd(0, 12'h000, q); check("R10 control cleared", q, 32'h0);
        rd(0, 12'h008, q); check("R10 low cleared", q, 32'h0);
        rd(0, 12'h00C, q); check("R10 high cleared", q, 32'h0);
        rd(0, 12'h010, q); check("R10 step reset", q, 32'h01000000);
        idle(3);
        rd(0, 12'h008, q); check("R2 idle after reset", q, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule